// File: doc/BRIEF.md
# Streaming word collector for a register slave

This block sits behind a 32-bit memory-mapped register slave and turns one register offset into a streaming port. Each accepted bus write to the data offset is stored in the next location of a small internal RAM rather than overwriting a single register. After eight words have arrived, the block raises a done flag and presents the assembled 256-bit message on a parallel output. A write to the control offset clears the flag. A registered read path returns the control, last-word, result and status values.

The write side follows valid/ready rules. The slave's handshake drives `wr_valid` and `wr_ready`, and a word is taken on exactly the clock where both are high. When either is low, nothing is captured and nothing changes. The block never stalls the bus, so back-pressure is whatever the slave applies through `wr_ready`. A read request gets its data two clocks later, and the data and its valid pulse leave on the same edge.

Top module: `msg_collector`

## Requirements
- R1: After a synchronous active-low reset, `word_cnt` is 0, `done` is 0, `msg_out` is all zero and `rd_valid` is 0.
- R2: An accepted write with `wr_offs` = 2'b01 (the data offset) is stored as word number `word_cnt`. Word i appears in `msg_out[32*i+31:32*i]` on the next clock, and `word_cnt` increments by one.
- R3: A write is captured only on a clock where `wr_valid` and `wr_ready` are both 1. When either is 0, `word_cnt`, `done` and `msg_out` keep their values.
- R4: `wr_strb` bit b enables byte b (`wr_data[8b+7:8b]`) of the stored word. A byte whose strobe is 0 keeps the previous content of that word slot, which is zero after reset.
- R5: `word_cnt` wraps from 7 to 0 on the eighth data write, and `done` goes to 1 on the clock after that eighth word is stored, not earlier.
- R6: `done` stays at 1 until reset or until an accepted write with `wr_offs` = 2'b00 (any data). Accepted writes to offsets 2'b10 and 2'b11 change none of `done`, `word_cnt` or `msg_out`.
- R7: A read request (`rd_req` = 1 for one clock) produces exactly one `rd_valid` pulse, two clocks later, with `rd_data` valid in that same cycle.
- R8: The read map is as follows. Offset 0 returns {31'b0, done}. Offset 1 returns the most recently stored word. Offset 2 returns `proc_result`. Offset 3 returns {done, 28'b0, word_cnt}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write-channel valid from the slave |
| wr_ready | input | 1 | Write-channel ready from the slave |
| wr_offs | input | 2 | Decoded register offset of the write |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte write enables |
| rd_req | input | 1 | Read request, one clock per read |
| rd_offs | input | 2 | Register offset of the read |
| proc_result | input | 32 | Processing result returned at offset 2 |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, two clocks after the request |
| msg_out | output | 256 | Assembled message, word 0 in the low bits |
| word_cnt | output | 3 | Number of words in the current message modulo 8 |
| done | output | 1 | Eight words received since the last clear |

## Verification
The hardest case to reach is a partial-strobe write that lands on a word slot already holding data. Reaching it needs a full eight-word pass, so that the counter wraps back to slot 0. The bench therefore fills a complete message, starting with a partial-strobe first word. It then writes slot 0 again with the complementary strobes, and checks that the bytes merge and that `done` survives the wrap. The bench also holds valid high without ready, and ready high without valid, on the data offset, and confirms that the count and the message do not move.

// File: rtl/coll_pkg.sv
package coll_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 8;
  localparam int DEPTH   = 16;

  typedef enum logic [1:0] {
    OFF_CTRL = 2'b00,
    OFF_DATA = 2'b01,
    OFF_RES  = 2'b10,
    OFF_STAT = 2'b11
  } reg_off_e;
endpackage

// File: rtl/coll_store.sv
module coll_store #(
  parameter int W     = 32,
  parameter int NW    = 8,
  parameter int DEPTH = 16,
  localparam int NB    = W / 8,
  localparam int CNT_W = $clog2(NW),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [1:0]        offs,
  input  logic [W-1:0]      data,
  input  logic [NB-1:0]     strb,
  output logic [NW*W-1:0]   msg,
  output logic [CNT_W-1:0]  cnt,
  output logic              done,
  output logic [W-1:0]      last_word
);
  import coll_pkg::*;

  logic [W-1:0]  ram [DEPTH];
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] last_addr;
  logic [W-1:0]  merged;
  logic          data_hit;
  logic          ctrl_hit;

  assign data_hit = acc && (offs == OFF_DATA);
  assign ctrl_hit = acc && (offs == OFF_CTRL);
  assign wr_addr  = AW'(cnt);

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      merged[8*b +: 8] = strb[b] ? data[8*b +: 8] : ram[wr_addr][8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ram[k] <= '0;
      last_addr <= '0;
    end else if (data_hit) begin
      ram[wr_addr] <= merged;
      last_addr    <= wr_addr;
    end
  end

  assign last_word = ram[last_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      if (data_hit) begin
        cnt <= (cnt == CNT_W'(NW-1)) ? '0 : cnt + 1'b1;
      end
      if (data_hit && cnt == CNT_W'(NW-1)) begin
        done <= 1'b1;
      end else if (ctrl_hit) begin
        done <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        msg[i*W +: W] <= '0;
      end else if (data_hit && cnt == CNT_W'(i)) begin
        msg[i*W +: W] <= merged;
      end
    end
  end
endmodule

// File: rtl/coll_readback.sv
module coll_readback #(
  parameter int W     = 32,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [1:0]       offs,
  input  logic             done,
  input  logic [CNT_W-1:0] cnt,
  input  logic [W-1:0]     last_word,
  input  logic [W-1:0]     result,
  output logic [W-1:0]     data,
  output logic             valid
);
  import coll_pkg::*;

  logic       s1_req;
  logic [1:0] s1_offs;
  logic [W-1:0] sel;

  always_comb begin
    case (s1_offs)
      OFF_CTRL: sel = {{(W-1){1'b0}}, done};
      OFF_DATA: sel = last_word;
      OFF_RES:  sel = result;
      default:  sel = {done, {(W-1-CNT_W){1'b0}}, cnt};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_req  <= 1'b0;
      s1_offs <= '0;
      valid   <= 1'b0;
      data    <= '0;
    end else begin
      s1_req  <= req;
      s1_offs <= offs;
      valid   <= s1_req;
      if (s1_req) data <= sel;
    end
  end
endmodule

// File: rtl/msg_collector.sv
module msg_collector #(
  parameter int W     = coll_pkg::WORD_W,
  parameter int NW    = coll_pkg::N_WORDS,
  parameter int DEPTH = coll_pkg::DEPTH,
  localparam int NB    = W / 8,
  localparam int CNT_W = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_ready,
  input  logic [1:0]        wr_offs,
  input  logic [W-1:0]      wr_data,
  input  logic [NB-1:0]     wr_strb,
  input  logic              rd_req,
  input  logic [1:0]        rd_offs,
  input  logic [W-1:0]      proc_result,
  output logic [W-1:0]      rd_data,
  output logic              rd_valid,
  output logic [NW*W-1:0]   msg_out,
  output logic [CNT_W-1:0]  word_cnt,
  output logic              done
);
  logic         acc;
  logic [W-1:0] last_word;

  assign acc = wr_valid && wr_ready;

  coll_store #(.W(W), .NW(NW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .acc(acc), .offs(wr_offs), .data(wr_data),
    .strb(wr_strb), .msg(msg_out), .cnt(word_cnt), .done(done),
    .last_word(last_word)
  );

  coll_readback #(.W(W), .CNT_W(CNT_W)) u_read (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .offs(rd_offs), .done(done),
    .cnt(word_cnt), .last_word(last_word), .result(proc_result),
    .data(rd_data), .valid(rd_valid)
  );
endmodule

// File: rtl/msg_collector_chk.sv
module msg_collector_chk #(
  parameter int W     = 32,
  parameter int NW    = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [1:0]       wr_offs,
  input logic             rd_req,
  input logic             rd_valid,
  input logic [NW*W-1:0]  msg_out,
  input logic [CNT_W-1:0] word_cnt,
  input logic             done
);
  logic acc;
  assign acc = wr_valid && wr_ready;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_offs == 2'b01) |=> (word_cnt == CNT_W'($past(word_cnt) + 1'b1)));

  a_r3_hold_without_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(word_cnt) && $stable(msg_out) && $stable(done)));

  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_offs == 2'b01 && word_cnt == CNT_W'(NW-1)) |=> done);

  a_r6_clear_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_offs == 2'b00) |=> !done);

  a_r6_other_offsets_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_offs[1]) |=> ($stable(word_cnt) && $stable(msg_out) && $stable(done)));

  a_r7_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> ##1 rd_valid);

  a_r7_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req, 2));
endmodule

bind msg_collector msg_collector_chk #(.W(W), .NW(NW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_offs(wr_offs), .rd_req(rd_req), .rd_valid(rd_valid), .msg_out(msg_out),
  .word_cnt(word_cnt), .done(done)
);

// File: tb/tb_msg_collector.sv
module tb_msg_collector;
  localparam int HALF = 10;

  logic         clk = 0;
  logic         rst_n;
  logic         wr_valid, wr_ready;
  logic [1:0]   wr_offs, rd_offs;
  logic [31:0]  wr_data, proc_result, rd_data;
  logic [3:0]   wr_strb;
  logic         rd_req, rd_valid, done;
  logic [255:0] msg_out;
  logic [2:0]   word_cnt;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_w [8];

  always #HALF clk = ~clk;

  msg_collector dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_offs(wr_offs), .wr_data(wr_data), .wr_strb(wr_strb), .rd_req(rd_req),
    .rd_offs(rd_offs), .proc_result(proc_result), .rd_data(rd_data),
    .rd_valid(rd_valid), .msg_out(msg_out), .word_cnt(word_cnt), .done(done)
  );

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_msg();
    logic [255:0] m;
    for (int i = 0; i < 8; i++) m[32*i +: 32] = exp_w[i];
    return m;
  endfunction

  task automatic bus_write(logic [1:0] o, logic [31:0] d, logic [3:0] s,
                           logic v, logic r);
    @(negedge clk);
    wr_offs = o; wr_data = d; wr_strb = s; wr_valid = v; wr_ready = r;
    @(negedge clk);
    wr_valid = 0; wr_ready = 0;
  endtask

  task automatic bus_read(string req, logic [1:0] o, logic [31:0] exp);
    @(negedge clk);
    rd_req = 1; rd_offs = o;
    @(negedge clk);
    rd_req = 0;
    check({req, " valid low one clock after request"}, 256'(rd_valid), 256'(0));
    @(negedge clk);
    check({req, " valid two clocks after request"}, 256'(rd_valid), 256'(1));
    check({req, " read data"}, 256'(rd_data), 256'(exp));
    @(negedge clk);
    check({req, " single valid pulse"}, 256'(rd_valid), 256'(0));
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) exp_w[i] = 0;
    check("R1 count", 256'(word_cnt), 256'(0));
    check("R1 done", 256'(done), 256'(0));
    check("R1 message", msg_out, 256'(0));
    check("R1 rd_valid", 256'(rd_valid), 256'(0));
  endtask

  task automatic t_handshake();
    bus_write(2'b01, 32'hDEAD_BEEF, 4'hF, 1, 0);
    check("R3 valid without ready count", 256'(word_cnt), 256'(0));
    check("R3 valid without ready message", msg_out, 256'(0));
    bus_write(2'b01, 32'hDEAD_BEEF, 4'hF, 0, 1);
    check("R3 ready without valid count", 256'(word_cnt), 256'(0));
    check("R3 ready without valid message", msg_out, 256'(0));
  endtask

  task automatic t_fill();
    bus_write(2'b01, 32'hAABB_CCDD, 4'b0101, 1, 1);
    exp_w[0] = 32'h00BB_00DD;
    check("R4 partial strobe on fresh slot", msg_out, exp_msg());
    check("R2 count after first word", 256'(word_cnt), 256'(1));
    for (int i = 1; i < 8; i++) begin
      bus_write(2'b01, 32'h1000_0000 * i + 32'h0101 * i, 4'hF, 1, 1);
      exp_w[i] = 32'h1000_0000 * i + 32'h0101 * i;
      if (i == 6) check("R5 done low before eighth word", 256'(done), 256'(0));
    end
    check("R2 full message placement", msg_out, exp_msg());
    check("R5 count wraps to zero", 256'(word_cnt), 256'(0));
    check("R5 done after eighth word", 256'(done), 256'(1));
  endtask

  task automatic t_inert();
    bus_write(2'b10, 32'hFFFF_FFFF, 4'hF, 1, 1);
    bus_write(2'b11, 32'hFFFF_FFFF, 4'hF, 1, 1);
    check("R6 other offsets keep done", 256'(done), 256'(1));
    check("R6 other offsets keep count", 256'(word_cnt), 256'(0));
    check("R6 other offsets keep message", msg_out, exp_msg());
  endtask

  task automatic t_reads();
    proc_result = 32'h5A5A_0F0F;
    bus_read("R8 offset0 done", 2'b00, 32'h0000_0001);
    bus_read("R8 offset1 last word", 2'b01, exp_w[7]);
    bus_read("R8 offset2 result", 2'b10, 32'h5A5A_0F0F);
    bus_read("R8 offset3 status", 2'b11, 32'h8000_0000);
  endtask

  task automatic t_wrap_merge();
    bus_write(2'b01, 32'h1122_3344, 4'b1010, 1, 1);
    exp_w[0] = 32'h11BB_33DD;
    check("R4 strobe merge after wrap", msg_out, exp_msg());
    check("R2 count after wrap write", 256'(word_cnt), 256'(1));
    check("R6 done kept across wrap", 256'(done), 256'(1));
    bus_read("R8 offset1 after merge", 2'b01, 32'h11BB_33DD);
  endtask

  task automatic t_clear();
    bus_write(2'b00, 32'h0000_0000, 4'hF, 1, 1);
    check("R6 control write clears done", 256'(done), 256'(0));
    check("R6 clear keeps message", msg_out, exp_msg());
    bus_read("R8 offset3 after clear", 2'b11, 32'h0000_0001);
  endtask

  initial begin
    #(2 * HALF * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wr_valid = 0; wr_ready = 0; wr_offs = 0; wr_data = 0; wr_strb = 0;
    rd_req = 0; rd_offs = 0; proc_result = 0; rst_n = 0;
    t_reset();
    t_handshake();
    t_fill();
    t_inert();
    t_reads();
    t_wrap_merge();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule